// File: doc/BRIEF.md
# Banked Memory Paging Controller

This block translates every access of a CPU with a 16-bit address bus into a physical location inside a 64 KB ROM and a 128 KB RAM. Both memories are divided into 16 KB pages. The top two address bits choose one of four slots. The remaining fourteen bits pass straight through as the offset within the page. For each access the block reports whether the slot holds ROM, which page the slot holds, and whether the memory write may go ahead.

Two 8-bit paging registers set the slot map. The CPU loads them with I/O writes to two exact 16-bit port addresses. A normal layout places a selectable ROM page under slot 0, two fixed RAM pages in slots 1 and 2, and a selectable RAM page in slot 3. A special layout places RAM in all four slots, using one of four fixed patterns. A sticky lock bit freezes the map until the next reset.

The slot map is held in registers. A paging write therefore takes effect on the access that follows the clock edge that completes it.

Top module: `mem_pager_top`

## Requirements
- R1: `offset` always equals `cpu_addr[13:0]`, and the slot used for translation is `cpu_addr[15:14]`.
- R2: An I/O write (`io_wr`=1) whose address is exactly 0x7FFD loads the primary register. Any other address, such as 0x7FFC or 0xFFFD, leaves it unchanged.
- R3: A primary-register write with data bit 5 set raises a lock. Later writes cannot clear the lock; only reset clears it.
- R4: The slot map does not change on the write that raises the lock, nor on any later write while the lock is set.
- R5: When secondary bit 0 is 1, every slot holds RAM and the primary register has no effect. Secondary bits 2:1 select the pages for slots 0..3: 00 gives 0,1,2,3; 01 gives 4,5,6,7; 10 gives 4,5,6,3; 11 gives 4,7,6,3.
- R6: When secondary bit 0 is 0, slot 0 holds ROM page {secondary bit 2, primary bit 4}.
- R7: When secondary bit 0 is 0, slot 1 holds RAM page 5, slot 2 holds RAM page 2, and slot 3 holds the RAM page given by primary bits 2:0.
- R8: `mem_we` is `mem_wr` when the addressed slot holds RAM, and 0 when it holds ROM.
- R9: After reset, slot 0 holds ROM 0, slot 1 holds RAM 5, slot 2 holds RAM 2, slot 3 holds RAM 0, and the lock is clear.
- R10: The map does not change during the cycle of a paging write. The new map appears after the clock edge on which the write is taken.
- R11: An I/O write to exactly 0x1FFD loads the secondary register. Nearby addresses leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address, used for both memory and I/O cycles |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| mem_wr | input | 1 | Memory write strobe |
| wr_data | input | 8 | CPU write data |
| is_rom | output | 1 | The addressed slot holds ROM |
| page | output | 3 | Physical page number (ROM pages use values 0..3) |
| offset | output | 14 | Byte offset inside the page |
| mem_we | output | 1 | Memory write enable, blocked for ROM |

## Verification
The bench builds the block with its default parameters: ports 0x7FFD and 0x1FFD, and lock bit 5. This covers all eight RAM pages, all four ROM pages and all four special layouts. Random paging writes are aimed mostly at the two ports, with some aimed at neighbouring addresses. They reach every combination of mode and page select. A rare random lock bit then tests that the map stays frozen under continued writes, and a second reset shows that the lock is released.

// File: rtl/mem_pager_pkg.sv
package mem_pager_pkg;
  localparam int PAGE_W    = 3;
  localparam int SLOT_W    = 2;
  localparam int NUM_SLOTS = 1 << SLOT_W;

  typedef struct packed {
    logic              is_rom;
    logic [PAGE_W-1:0] page;
  } slot_map_t;

  // primary register fields that influence the map
  typedef struct packed {
    logic       rom_lo;
    logic [2:0] ram_sel;
  } pri_fields_t;

  // secondary register fields that influence the map
  typedef struct packed {
    logic [1:0] cfg;
    logic       special;
  } sec_fields_t;
endpackage

// File: rtl/pager_regs.sv
module pager_regs
  import mem_pager_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 8,
  parameter logic [15:0] PRI_PORT = 16'h7FFD,
  parameter logic [15:0] SEC_PORT = 16'h1FFD,
  parameter int          LOCK_BIT = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] wr_data,
  output pri_fields_t       pri_nxt,
  output sec_fields_t       sec_nxt,
  output logic              lock_q,
  output logic              map_load
);
  logic hit_pri, hit_sec, lock_req;
  pri_fields_t pri_q;
  sec_fields_t sec_q;
  logic unused_data;

  assign hit_pri  = io_wr && (io_addr == ADDR_W'(PRI_PORT));
  assign hit_sec  = io_wr && (io_addr == ADDR_W'(SEC_PORT));
  assign lock_req = hit_pri && wr_data[LOCK_BIT];

  assign pri_nxt  = hit_pri ? pri_fields_t'({wr_data[4], wr_data[2:0]}) : pri_q;
  assign sec_nxt  = hit_sec ? sec_fields_t'(wr_data[2:0]) : sec_q;
  assign map_load = (hit_pri || hit_sec) && !lock_q && !lock_req;
  assign unused_data = ^{wr_data[DATA_W-1:6], wr_data[3]};

  always_ff @(posedge clk) begin
    if (rst) begin
      pri_q  <= '0;
      sec_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      pri_q  <= pri_nxt;
      sec_q  <= sec_nxt;
      lock_q <= lock_q | lock_req;
    end
  end

  p_lock_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> lock_q);
  p_lock_set_r3: assert property (@(posedge clk) disable iff (rst)
    lock_req |=> lock_q);
endmodule

// File: rtl/pager_map_calc.sv
module pager_map_calc
  import mem_pager_pkg::*;
(
  input  pri_fields_t                 pri,
  input  sec_fields_t                 sec,
  output slot_map_t [NUM_SLOTS-1:0]   map
);
  function automatic slot_map_t ram(input int unsigned p);
    return '{is_rom: 1'b0, page: PAGE_W'(p)};
  endfunction

  always_comb begin
    if (sec.special) begin
      unique case (sec.cfg)
        2'b00: map = {ram(3), ram(2), ram(1), ram(0)};
        2'b01: map = {ram(7), ram(6), ram(5), ram(4)};
        2'b10: map = {ram(3), ram(6), ram(5), ram(4)};
        default: map = {ram(3), ram(6), ram(7), ram(4)};
      endcase
    end else begin
      map[0] = '{is_rom: 1'b1, page: {1'b0, sec.cfg[1], pri.rom_lo}};
      map[1] = ram(5);
      map[2] = ram(2);
      map[3] = '{is_rom: 1'b0, page: pri.ram_sel};
    end
  end
endmodule

// File: rtl/pager_slot_map.sv
module pager_slot_map
  import mem_pager_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        load,
  input  slot_map_t [NUM_SLOTS-1:0]   map_in,
  input  slot_map_t [NUM_SLOTS-1:0]   map_rst,
  output slot_map_t [NUM_SLOTS-1:0]   map_q
);
  always_ff @(posedge clk) begin
    if (rst)       map_q <= map_rst;
    else if (load) map_q <= map_in;
  end

  for (genvar s = 1; s < NUM_SLOTS; s++) begin : g_chk
    p_upper_ram_r7: assert property (@(posedge clk) disable iff (rst)
      !map_q[s].is_rom);
  end
endmodule

// File: rtl/mem_pager_top.sv
module mem_pager_top
  import mem_pager_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 8,
  parameter logic [15:0] PRI_PORT = 16'h7FFD,
  parameter logic [15:0] SEC_PORT = 16'h1FFD,
  parameter int          LOCK_BIT = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        cpu_addr,
  input  logic                     io_wr,
  input  logic                     mem_wr,
  input  logic [DATA_W-1:0]        wr_data,
  output logic                     is_rom,
  output logic [PAGE_W-1:0]        page,
  output logic [ADDR_W-SLOT_W-1:0] offset,
  output logic                     mem_we
);
  localparam int OFFS_W = ADDR_W - SLOT_W;

  pri_fields_t pri_nxt;
  sec_fields_t sec_nxt;
  logic        lock_q, map_load;
  slot_map_t [NUM_SLOTS-1:0] map_nxt, map_rst, map_q;
  logic [SLOT_W-1:0] slot;

  pager_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRI_PORT(PRI_PORT),
    .SEC_PORT(SEC_PORT), .LOCK_BIT(LOCK_BIT)
  ) u_regs (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_addr(cpu_addr),
    .wr_data(wr_data), .pri_nxt(pri_nxt), .sec_nxt(sec_nxt),
    .lock_q(lock_q), .map_load(map_load)
  );

  pager_map_calc u_calc (.pri(pri_nxt), .sec(sec_nxt), .map(map_nxt));
  pager_map_calc u_calc_rst (.pri('0), .sec('0), .map(map_rst));

  pager_slot_map u_map (
    .clk(clk), .rst(rst), .load(map_load), .map_in(map_nxt),
    .map_rst(map_rst), .map_q(map_q)
  );

  assign slot   = cpu_addr[ADDR_W-1 -: SLOT_W];
  assign offset = cpu_addr[OFFS_W-1:0];
  assign is_rom = map_q[slot].is_rom;
  assign page   = map_q[slot].page;
  assign mem_we = mem_wr && !map_q[slot].is_rom;

  p_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> $stable(map_q));
  p_lockwrite_r4: assert property (@(posedge clk) disable iff (rst)
    (io_wr && cpu_addr == ADDR_W'(PRI_PORT) && wr_data[LOCK_BIT]) |=> $stable(map_q));
  p_rom_nowrite_r8: assert property (@(posedge clk) disable iff (rst)
    is_rom |-> !mem_we);
  p_idle_stable_r10: assert property (@(posedge clk) disable iff (rst)
    !io_wr |=> $stable(map_q));
endmodule

// File: tb/tb_mem_pager_top.sv
`timescale 1ns/1ps
module tb_mem_pager_top;
  logic        clk = 0, rst = 1;
  logic [15:0] cpu_addr = 0;
  logic        io_wr = 0, mem_wr = 0;
  logic [7:0]  wr_data = 0;
  logic        is_rom, mem_we;
  logic [2:0]  page;
  logic [13:0] offset;

  int total = 0, bad = 0;
  logic [7:0] m_pri, m_sec;
  logic       m_lock;
  logic [3:0] m_map [4];

  mem_pager_top dut (.clk(clk), .rst(rst), .cpu_addr(cpu_addr), .io_wr(io_wr),
    .mem_wr(mem_wr), .wr_data(wr_data), .is_rom(is_rom), .page(page),
    .offset(offset), .mem_we(mem_we));

  always #4 clk = ~clk;

  function automatic logic [3:0] exp_slot(logic [7:0] p, logic [7:0] s, int k);
    int pat [4][4] = '{'{0,1,2,3}, '{4,5,6,7}, '{4,5,6,3}, '{4,7,6,3}};
    if (s[0]) return {1'b0, 3'(pat[s[2:1]][k])};
    case (k)
      0: return {1'b1, 1'b0, s[2], p[4]};
      1: return {1'b0, 3'd5};
      2: return {1'b0, 3'd2};
      default: return {1'b0, p[2:0]};
    endcase
  endfunction

  task automatic model_reset();
    m_pri = 0; m_sec = 0; m_lock = 0;
    for (int k = 0; k < 4; k++) m_map[k] = exp_slot(0, 0, k);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; io_wr = 0; mem_wr = 0;
    repeat (3) @(negedge clk);
    rst = 0; model_reset();
  endtask

  task automatic check(logic [15:0] a, logic wr, string tag);
    logic [3:0] e;
    cpu_addr = a; mem_wr = wr; #1;
    e = m_map[a[15:14]];
    total++;
    if (is_rom !== e[3] || page !== e[2:0] || offset !== a[13:0] ||
        mem_we !== (wr && !e[3])) begin
      bad++;
      $display("FAIL %s addr=%h act rom=%b page=%0d off=%h we=%b exp rom=%b page=%0d off=%h we=%b",
        tag, a, is_rom, page, offset, mem_we, e[3], e[2:0], a[13:0], wr && !e[3]);
    end
    mem_wr = 0;
  endtask

  task automatic check_all(string tag);
    for (int k = 0; k < 4; k++) check({2'(k), 14'($urandom)}, 1'($urandom), tag);
  endtask

  task automatic io_write(logic [15:0] a, logic [7:0] d);
    logic hp, hs, lreq;
    @(negedge clk);
    cpu_addr = a; wr_data = d; io_wr = 1;
    @(posedge clk); #1;
    io_wr = 0;
    hp = (a == 16'h7FFD); hs = (a == 16'h1FFD); lreq = hp && d[5];
    if (hp) m_pri = d;
    if (hs) m_sec = d;
    if ((hp || hs) && !m_lock && !lreq)
      for (int k = 0; k < 4; k++) m_map[k] = exp_slot(m_pri, m_sec, k);
    m_lock = m_lock | lreq;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd4242);
    do_reset();
    // R9 reset state, R1 offset pass-through
    check_all("R9");
    check(16'h3FFF, 1, "R8 rom write blocked");
    check(16'hC000, 1, "R1");
    // R7 slot3 pages, R6 rom pages
    for (int v = 0; v < 8; v++) begin
      io_write(16'h7FFD, 8'(v) | 8'h10);
      check(16'hC123, 1, "R7");
      check(16'h0042, 1, "R6");
    end
    io_write(16'h1FFD, 8'h04);
    check(16'h0000, 0, "R11 R6 rom page 3");
    // R5 special layouts
    for (int c = 0; c < 4; c++) begin
      io_write(16'h1FFD, 8'(c << 1) | 8'h01);
      check_all("R5");
    end
    io_write(16'h7FFD, 8'h07);
    check_all("R5 primary ignored");
    // R2 / R11 near-miss ports
    io_write(16'h1FFD, 8'h00);
    io_write(16'h7FFC, 8'h03);
    io_write(16'hFFFD, 8'h06);
    io_write(16'h1FFC, 8'h01);
    io_write(16'h3FFD, 8'h01);
    check_all("R2 R11 ignored ports");
    // R10: new map not visible during the write cycle
    @(negedge clk);
    cpu_addr = 16'h7FFD; wr_data = 8'h04; io_wr = 1; #1;
    total++;
    if (page !== m_map[1][2:0]) begin
      bad++; $display("FAIL R10 early change act=%0d exp=%0d", page, m_map[1][2:0]);
    end
    @(posedge clk); #1; io_wr = 0;
    m_pri = 8'h04;
    for (int k = 0; k < 4; k++) m_map[k] = exp_slot(m_pri, m_sec, k);
    @(negedge clk);
    check(16'hC000, 0, "R10 after edge");
    // R3/R4 lock
    io_write(16'h7FFD, 8'h21);
    check_all("R4 lock write no change");
    io_write(16'h7FFD, 8'h03);
    io_write(16'h1FFD, 8'h05);
    check_all("R3 R4 frozen");
    do_reset();
    check_all("R9 lock released");
    io_write(16'h7FFD, 8'h06);
    check(16'hC000, 0, "R3 reset clears lock");
    // random
    for (int i = 0; i < 400; i++) begin
      int r;
      logic [15:0] a;
      logic [7:0]  d;
      r = $urandom_range(0, 9);
      a = (r < 5) ? 16'h7FFD : (r < 9) ? 16'h1FFD : 16'($urandom);
      d = 8'($urandom);
      if ($urandom_range(0, 60) != 0) d[5] = 0;
      io_write(a, d);
      check(16'($urandom), 1'($urandom), "R2 R5 R6 R7 R8 random");
      if (m_lock && $urandom_range(0, 20) == 0) do_reset();
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule